// File: doc/BRIEF.md
# Key-Locked Cross-Domain Register Shadow

This block sits between a fast register bus and a slow, always-on 32 kHz domain. It keeps a bus-side shadow of eight 32-bit scratch words and a small control register. Those registers can only be changed after software opens a two-word key lock. Every accepted scratch write is carried into the slow domain by a toggle request/acknowledge handshake. A pending flag stays visible on the bus until the acknowledge has come back, so software polls it instead of waiting a fixed time.

A reload command runs the handshake the other way. The slow domain samples a status word it owns, and the bus-side mirror register takes that value once the transfer completes. Every slow-domain result appears on a one-cycle strobe port, so the counter and alarm logic outside this block can pick it up.

Top module: `keyed_shadow_bridge`

## Requirements
- R1: After reset the block is locked: register 0x50 reads 0 (bit 23 unlocked flag clear, bit 21 sync enable clear), 0x68 reads 0, 0x54 reads 0, and every scratch word reads 0.
- R2: A write of 0x83E70B13 to 0x70, followed by a write of 0x95A4F1E0 to 0x74 as the very next bus write, sets bit 23 of 0x50 from the next cycle on.
- R3: The block stays locked if the key 0 value is wrong, if the key 1 value is wrong, or if any other bus write falls between the two key writes. A correct pair written later still unlocks it.
- R4: While the block is locked, writes to 0x50 and to the scratch words change nothing. Reads still return the current values.
- R5: Once unlocked, the block stays unlocked until reset, whatever is written to the key registers.
- R6: Scratch word i (0 to 7) sits at address 0x30 + 4*i and reads back the last accepted write to it.
- R7: With bit 21 of 0x50 set, an accepted scratch write sets bit 0 of 0x68 in the next cycle. The slow domain then gives exactly one `slow_wr_valid` strobe carrying the word index and the data. Bit 0 returns to 0 after the acknowledge is back in the bus domain.
- R8: With bit 21 clear, an accepted scratch write updates the shadow only: bit 0 of 0x68 stays 0 and no slow strobe appears.
- R9: A scratch write made while bit 0 of 0x68 is set is ignored. It changes neither the shadow nor the word in flight.
- R10: Writing a 1 to bit 31 of 0x68 starts a reload whether the block is locked or not. Bit 1 of 0x68 reads 1 until the reload completes, and from then on 0x54 holds the `slow_status` value that the slow domain sampled. A reload command given while bit 1 is set is ignored, and bit 31 always reads 0.
- R11: The key registers 0x70 and 0x74, and any unmapped address, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |
| slow_clk | input | 1 | Slow 32 kHz domain clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| slow_status | input | 32 | Status word owned by the slow domain, sampled on reload |
| slow_wr_valid | output | 1 | One-slow-cycle strobe when a scratch transfer lands |
| slow_wr_idx | output | 3 | Scratch index of the landed transfer |
| slow_wr_data | output | 32 | Data of the landed transfer |

## Verification
The bench breaks the key sequence in each way it can: a wrong first key, a wrong second key, and a stray write placed between correct keys. A sequencer that only remembered that key 0 had been seen would unlock on the third case. It writes the same scratch word twice in back-to-back cycles. A design without the pending guard would overwrite the shadow, or change the held data while the slow side is capturing it, and the slow strobe count or data would then disagree. It issues reloads while still locked and with sync disabled, and it checks for strobes after unsynchronized writes, where a launch gated on the wrong bit would show extra transfers. Random scratch traffic is compared word by word against a model of the shadow and of the strobe sequence.

// File: rtl/kss_pkg.sv
// Shared constants and the scratch address decoder for the keyed shadow bridge.
// Assumes byte addressing with 32-bit aligned registers.
package kss_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int NUM_SCR   = 8;
    localparam int SCR_IDX_W = $clog2(NUM_SCR);

    localparam logic [ADDR_W-1:0] A_SCR0   = 8'h30;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h50;
    localparam logic [ADDR_W-1:0] A_MIRROR = 8'h54;
    localparam logic [ADDR_W-1:0] A_SYNC   = 8'h68;
    localparam logic [ADDR_W-1:0] A_KEY0   = 8'h70;
    localparam logic [ADDR_W-1:0] A_KEY1   = 8'h74;

    localparam logic [DATA_W-1:0] KEY0_VAL = 32'h83E70B13;
    localparam logic [DATA_W-1:0] KEY1_VAL = 32'h95A4F1E0;

    localparam int BIT_UNLOCKED = 23;
    localparam int BIT_SYNC_EN  = 21;
    localparam int BIT_RELOAD   = 31;

    typedef struct packed {
        logic                 hit;
        logic [SCR_IDX_W-1:0] idx;
    } scr_sel_t;

    // Maps a byte address onto a scratch word index, if it names one.
    function automatic scr_sel_t scr_decode(input logic [ADDR_W-1:0] a);
        scr_sel_t          r;
        logic [ADDR_W-1:0] off;
        off   = a - A_SCR0;
        r.hit = (a >= A_SCR0) && (off < ADDR_W'(NUM_SCR * 4)) && (off[1:0] == 2'b00);
        r.idx = off[SCR_IDX_W+1:2];
        return r;
    endfunction
endpackage

// File: rtl/kss_sync_bit.sv
// Multi-flop synchronizer for a single level or toggle signal.
// Assumes the input changes at most once per several destination clocks.
module kss_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES > 1) begin : g_multi
            // Shift the asynchronous input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_single
            // Single stage: register the input once.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kss_key_seq.sv
// Two-word key sequencer. The first key arms it, and the second key unlocks
// only when it is the very next bus write. The unlocked state holds until reset.
module kss_key_seq import kss_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked
);
    logic armed;
    logic key0_ok, key1_ok;

    assign key0_ok = (wr_addr == A_KEY0) && (wr_data == KEY0_VAL);
    assign key1_ok = (wr_addr == A_KEY1) && (wr_data == KEY1_VAL);

    // Re-arm on each bus write: only a correct first key leaves it armed.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (wr_en) armed <= key0_ok;
    end

    // Latch the unlocked state on a correct second key that follows an armed first key.
    always_ff @(posedge clk) begin
        if (!rst_n)                         unlocked <= 1'b0;
        else if (wr_en && armed && key1_ok) unlocked <= 1'b1;
    end
endmodule

// File: rtl/kss_slow_port.sv
// Slow-domain end of both handshakes. It detects request toggles, captures
// the held write or samples the status word, and returns each toggle as an ack.
// Assumes the bus side holds its data steady while a request is outstanding.
module kss_slow_port import kss_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 slow_clk,
    input  logic                 slow_rst_n,
    input  logic                 wr_req_tog,
    input  logic [SCR_IDX_W-1:0] hold_idx,
    input  logic [DATA_W-1:0]    hold_data,
    input  logic                 rl_req_tog,
    input  logic [DATA_W-1:0]    slow_status,
    output logic                 wr_ack_tog,
    output logic                 rl_ack_tog,
    output logic [DATA_W-1:0]    rl_data,
    output logic                 wr_valid,
    output logic [SCR_IDX_W-1:0] wr_idx,
    output logic [DATA_W-1:0]    wr_data
);
    logic wr_req_s, rl_req_s;

    kss_sync_bit #(.STAGES(SYNC_STAGES)) u_wr_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(wr_req_tog), .q(wr_req_s));
    kss_sync_bit #(.STAGES(SYNC_STAGES)) u_rl_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(rl_req_tog), .q(rl_req_s));

    // Land a write transfer: strobe once per request toggle and echo it as the ack.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            wr_ack_tog <= 1'b0;
            wr_valid   <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (wr_req_s != wr_ack_tog) begin
                wr_ack_tog <= wr_req_s;
                wr_valid   <= 1'b1;
                wr_idx     <= hold_idx;
                wr_data    <= hold_data;
            end
        end
    end

    // Serve a reload: sample the status word and echo the request as the ack.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            rl_ack_tog <= 1'b0;
            rl_data    <= '0;
        end else if (rl_req_s != rl_ack_tog) begin
            rl_ack_tog <= rl_req_s;
            rl_data    <= slow_status;
        end
    end
endmodule

// File: rtl/keyed_shadow_bridge.sv
// Key-locked register shadow with a pending-flag handshake into a slow domain.
// Bus reads are combinational. There is one write transfer and one reload in
// flight at most, and software polls the pending bits before the next access.
module keyed_shadow_bridge import kss_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 bus_clk,
    input  logic                 bus_rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 slow_clk,
    input  logic                 slow_rst_n,
    input  logic [DATA_W-1:0]    slow_status,
    output logic                 slow_wr_valid,
    output logic [SCR_IDX_W-1:0] slow_wr_idx,
    output logic [DATA_W-1:0]    slow_wr_data
);
    logic                 unlocked;
    logic                 sync_en_q;
    logic [DATA_W-1:0]    shadow [NUM_SCR];
    logic                 wr_req_tog, rl_req_tog;
    logic                 wr_ack_tog, rl_ack_tog;
    logic                 wr_ack_s, rl_ack_s;
    logic                 rl_done;
    logic [SCR_IDX_W-1:0] hold_idx;
    logic [DATA_W-1:0]    hold_data;
    logic [DATA_W-1:0]    rl_data;
    logic [DATA_W-1:0]    mirror_q;
    logic [1:0]           pend;
    scr_sel_t             wsel, rsel;
    logic                 scr_accept, launch, reload_go, ctrl_wr;

    kss_key_seq u_keys (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .unlocked(unlocked));

    assign wsel       = scr_decode(wr_addr);
    assign rsel       = scr_decode(rd_addr);
    assign pend       = {rl_req_tog ^ rl_done, wr_req_tog ^ wr_ack_s};
    assign scr_accept = wr_en && unlocked && wsel.hit && !pend[0];
    assign launch     = scr_accept && sync_en_q;
    assign ctrl_wr    = wr_en && unlocked && (wr_addr == A_CTRL);
    assign reload_go  = wr_en && (wr_addr == A_SYNC) && wr_data[BIT_RELOAD] && !pend[1];

    // Control register: the sync enable is writable only when unlocked.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)   sync_en_q <= 1'b0;
        else if (ctrl_wr) sync_en_q <= wr_data[BIT_SYNC_EN];
    end

    // Scratch shadow: update the addressed word on an accepted write.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            for (int i = 0; i < NUM_SCR; i++) shadow[i] <= '0;
        end else if (scr_accept) begin
            shadow[wsel.idx] <= wr_data;
        end
    end

    // Write launch: hold the word steady and flip the request toggle.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            wr_req_tog <= 1'b0;
            hold_idx   <= '0;
            hold_data  <= '0;
        end else if (launch) begin
            wr_req_tog <= ~wr_req_tog;
            hold_idx   <= wsel.idx;
            hold_data  <= wr_data;
        end
    end

    // Reload: flip the request, then load the mirror when the ack returns.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            rl_req_tog <= 1'b0;
            rl_done    <= 1'b0;
            mirror_q   <= '0;
        end else begin
            if (reload_go) rl_req_tog <= ~rl_req_tog;
            if (rl_ack_s != rl_done) begin
                rl_done  <= rl_ack_s;
                mirror_q <= rl_data;
            end
        end
    end

    kss_sync_bit #(.STAGES(SYNC_STAGES)) u_wr_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(wr_ack_tog), .q(wr_ack_s));
    kss_sync_bit #(.STAGES(SYNC_STAGES)) u_rl_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(rl_ack_tog), .q(rl_ack_s));

    kss_slow_port #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .wr_req_tog(wr_req_tog), .hold_idx(hold_idx), .hold_data(hold_data),
        .rl_req_tog(rl_req_tog), .slow_status(slow_status),
        .wr_ack_tog(wr_ack_tog), .rl_ack_tog(rl_ack_tog), .rl_data(rl_data),
        .wr_valid(slow_wr_valid), .wr_idx(slow_wr_idx), .wr_data(slow_wr_data));

    // Read mux: fixed registers first, then the scratch window, else zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[BIT_UNLOCKED] = unlocked;
                rd_data[BIT_SYNC_EN]  = sync_en_q;
            end
            A_SYNC:   rd_data[1:0] = pend;
            A_MIRROR: rd_data      = mirror_q;
            default:  if (rsel.hit) rd_data = shadow[rsel.idx];
        endcase
    end
endmodule

// File: rtl/kss_checker.sv
// Temporal checks on the keyed shadow bridge, attached by bind.
// Assumes that both resets are asserted together at start-up.
module kss_checker import kss_pkg::*; (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              slow_clk,
    input logic              slow_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              unlocked,
    input logic              sync_en,
    input logic [1:0]        pend,
    input logic [DATA_W-1:0] hold_data,
    input logic [DATA_W-1:0] mirror,
    input logic              slow_wr_valid
);
    // R2: unlocking happens only on a correct second key write.
    p_unlock_cause_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == A_KEY1 && wr_data == KEY1_VAL));

    // R4: the sync enable cannot move while locked.
    p_locked_ctrl_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !unlocked |=> $stable(sync_en));

    // R5: the unlocked flag never drops outside reset.
    p_unlock_sticky_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$fell(unlocked));

    // R7: a write transfer starts only from a write made with sync enabled.
    p_launch_cause_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(pend[0]) |-> $past(wr_en && unlocked && sync_en));

    // R7: the slow strobe lasts exactly one slow cycle.
    p_strobe_single_r7: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        slow_wr_valid |=> !slow_wr_valid);

    // R9: the word in flight holds while a transfer is pending.
    p_hold_stable_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $past(pend[0]) |-> $stable(hold_data));

    // R10: the mirror changes only as a reload completes.
    p_mirror_on_done_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(mirror) |-> $fell(pend[1]));
endmodule

bind keyed_shadow_bridge kss_checker u_chk (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked), .sync_en(sync_en_q), .pend(pend),
    .hold_data(hold_data), .mirror(mirror_q),
    .slow_wr_valid(slow_wr_valid));

// File: tb/sim_keyed_shadow_bridge.sv
// Self-checking bench for the keyed shadow bridge: directed corners plus seeded random traffic.
module sim_keyed_shadow_bridge;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] slow_status = '0;
    logic        slow_wr_valid;
    logic [2:0]  slow_wr_idx;
    logic [31:0] slow_wr_data;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          pulses = 0;
    logic [2:0]  last_idx = '0;
    logic [31:0] last_data = '0;
    logic [31:0] exp_scr [8];
    logic        done = 1'b0;

    always #10 bus_clk = ~bus_clk;
    always #65 slow_clk = ~slow_clk;

    keyed_shadow_bridge u0 (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .slow_status(slow_status),
        .slow_wr_valid(slow_wr_valid), .slow_wr_idx(slow_wr_idx), .slow_wr_data(slow_wr_data));

    // Record each slow-domain strobe, sampled away from its active edge.
    always @(negedge slow_clk) begin
        if (slow_rst_n && slow_wr_valid) begin
            pulses    <= pulses + 1;
            last_idx  <= slow_wr_idx;
            last_data <= slow_wr_data;
        end
    end

    function automatic logic [7:0] scr_addr(input int i);
        return 8'h30 + 8'(4 * i);
    endfunction

    function automatic logic [31:0] ctrl_exp(input logic unl, input logic sen);
        return (32'(unl) << 23) | (32'(sen) << 21);
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge bus_clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL R7 watchdog: cycles=%0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge bus_clk);
        #2 wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle(input string req, input logic [1:0] mask);
        logic [31:0] v;
        v = 32'hFFFF_FFFF;
        for (int n = 0; n < 400; n++) begin
            bus_read(8'h68, v);
            if ((v[1:0] & mask) == 2'b00) break;
        end
        chk(req, {30'd0, v[1:0] & mask}, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge bus_clk);
    endtask

    initial begin
        logic [31:0] v;
        int p0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) exp_scr[i] = '0;

        idle(5);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        idle(3);

        // R1: reset state
        bus_read(8'h50, v); chk("R1 ctrl", v, 32'd0);
        bus_read(8'h68, v); chk("R1 sync", v, 32'd0);
        bus_read(8'h54, v); chk("R1 mirror", v, 32'd0);
        for (int i = 0; i < 8; i++) begin
            bus_read(scr_addr(i), v); chk("R1 scratch", v, 32'd0);
        end

        // R11: key registers and unmapped addresses read zero
        bus_read(8'h70, v); chk("R11 key0 read", v, 32'd0);
        bus_read(8'h74, v); chk("R11 key1 read", v, 32'd0);
        bus_read(8'h00, v); chk("R11 unmapped", v, 32'd0);
        bus_read(8'h31, v); chk("R11 misaligned", v, 32'd0);

        // R4: writes while locked are ignored
        bus_write(scr_addr(2), 32'hDEAD_BEEF);
        bus_write(8'h50, 32'h0020_0000);
        bus_read(scr_addr(2), v); chk("R4 scratch locked", v, 32'd0);
        bus_read(8'h50, v); chk("R4 ctrl locked", v, 32'd0);
        idle(30);
        chk("R4 no strobe", 32'(pulses), 32'd0);

        // R10: reload while locked; bit 1 pending, then the mirror updates
        slow_status = 32'hA5A5_0001;
        bus_write(8'h68, 32'h8000_0000);
        bus_read(8'h68, v); chk("R10 reload pending", v, 32'd2);
        bus_write(8'h68, 32'h8000_0000);
        wait_idle("R10 reload done", 2'b10);
        bus_read(8'h54, v); chk("R10 mirror", v, 32'hA5A5_0001);
        idle(40);
        bus_read(8'h68, v); chk("R10 second reload ignored", v, 32'd0);

        // R3: broken sequences keep the lock
        bus_write(8'h70, 32'h83E7_0B12);
        bus_write(8'h74, 32'h95A4_F1E0);
        bus_read(8'h50, v); chk("R3 wrong key0", v, 32'd0);
        bus_write(8'h70, 32'h83E7_0B13);
        bus_write(8'h74, 32'h95A4_F1E1);
        bus_read(8'h50, v); chk("R3 wrong key1", v, 32'd0);
        bus_write(8'h70, 32'h83E7_0B13);
        bus_write(8'h40, 32'h1111_1111);
        bus_write(8'h74, 32'h95A4_F1E0);
        bus_read(8'h50, v); chk("R3 write between keys", v, 32'd0);
        bus_write(8'h74, 32'h95A4_F1E0);
        bus_read(8'h50, v); chk("R3 key1 alone", v, 32'd0);

        // R2: correct pair unlocks
        bus_write(8'h70, 32'h83E7_0B13);
        bus_write(8'h74, 32'h95A4_F1E0);
        bus_read(8'h50, v); chk("R2 unlocked", v, ctrl_exp(1'b1, 1'b0));

        // R8: sync disabled, shadow only
        bus_write(scr_addr(1), 32'h0BAD_F00D); exp_scr[1] = 32'h0BAD_F00D;
        bus_read(8'h68, v); chk("R8 no pending", v, 32'd0);
        bus_read(scr_addr(1), v); chk("R8 shadow", v, exp_scr[1]);
        idle(40);
        chk("R8 no strobe", 32'(pulses), 32'd0);

        // Enable sync
        bus_write(8'h50, 32'h0020_0000);
        bus_read(8'h50, v); chk("R4 ctrl writable once unlocked", v, ctrl_exp(1'b1, 1'b1));

        // R7: directed transfer of the last word
        p0 = pulses;
        bus_write(scr_addr(7), 32'h1234_5678); exp_scr[7] = 32'h1234_5678;
        bus_read(8'h68, v); chk("R7 pending set", v, 32'd1);
        wait_idle("R7 pending clears", 2'b01);
        idle(12);
        chk("R7 one strobe", 32'(pulses - p0), 32'd1);
        chk("R7 strobe idx", 32'(last_idx), 32'd7);
        chk("R7 strobe data", last_data, 32'h1234_5678);
        bus_read(scr_addr(7), v); chk("R6 readback w7", v, exp_scr[7]);

        // R9: back-to-back write to the same word; the second is dropped
        p0 = pulses;
        bus_write(scr_addr(3), 32'hCAFE_0003); exp_scr[3] = 32'hCAFE_0003;
        bus_write(scr_addr(3), 32'hBEEF_0003);
        bus_read(scr_addr(3), v); chk("R9 shadow keeps first", v, 32'hCAFE_0003);
        wait_idle("R9 pending clears", 2'b01);
        idle(12);
        chk("R9 single strobe", 32'(pulses - p0), 32'd1);
        chk("R9 strobe data", last_data, 32'hCAFE_0003);

        // R6/R7/R9: seeded random traffic against the model
        for (int it = 0; it < 40; it++) begin
            int          idx;
            logic [31:0] d;
            logic        dbl;
            idx = int'($urandom_range(7, 0));
            d   = $urandom();
            dbl = 1'($urandom_range(1, 0));
            p0  = pulses;
            bus_write(scr_addr(idx), d); exp_scr[idx] = d;
            if (dbl) bus_write(scr_addr(int'($urandom_range(7, 0))), ~d);
            wait_idle("R7 random pending clears", 2'b01);
            idle(12);
            chk("R7 random strobe count", 32'(pulses - p0), 32'd1);
            chk("R7 random strobe idx", 32'(last_idx), 32'(idx));
            chk("R9 random strobe data", last_data, d);
        end
        for (int i = 0; i < 8; i++) begin
            bus_read(scr_addr(i), v); chk("R6 final readback", v, exp_scr[i]);
        end

        // R5: wrong keys after unlocking change nothing
        bus_write(8'h70, 32'h0);
        bus_write(8'h74, 32'h0);
        bus_read(8'h50, v); chk("R5 stays unlocked", v, ctrl_exp(1'b1, 1'b1));

        // R10: reload while unlocked with a new status word; bit 31 reads zero
        slow_status = 32'h0F0F_7788;
        bus_write(8'h68, 32'h8000_0000);
        bus_read(8'h68, v); chk("R10 bit31 reads zero", v & 32'h8000_0000, 32'd0);
        wait_idle("R10 second reload done", 2'b10);
        bus_read(8'h54, v); chk("R10 mirror update", v, 32'h0F0F_7788);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule